// File: doc/BRIEF.md
# Buffered Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port. The host places 16-bit words into a write-only data register. Each word passes, optionally through a holding buffer, into a 16-bit shift register. The shift register drives the serial data line one bit per qualified bit-clock enable. Words are left-justified, and 8, 10, 12 or 16 of their upper bits are sent, in either bit order.

The host sets the configuration through level inputs: word length, bit order, buffer use, and clock style. In continuous-clock style a bit moves only while the frame sync is high. In gated style every bit-clock enable moves a bit. The host keeps the transmitter fed by watching a data-empty flag, or an interrupt request built from that flag. If the shift register runs dry it sends its last word again and records an underrun.

Top module: `sst_tx`

## Requirements
- R1: After reset, `tde_o` is 1 and `sdo_o`, `irq_o` and `urun_o` are 0.
- R2: `word_len_i` selects bits per word: 0 gives 8, 1 gives 10, 2 gives 12 and 3 gives 16. After that many shift steps the next word starts.
- R3: Only the upper N bits of a written word (bits 15 down to 16-N) are sent. The low-order bits have no effect on `sdo_o`.
- R4: With `lsb_first_i` at 0 the word leaves bit 15 first. With 1 it leaves bit 16-N first and bit 15 last. During a shift step `sdo_o` shows the bit being sent.
- R5: A shift step occurs on a cycle with `tx_en_i` and `bit_en_i` high and with either `gated_clk_i` high or `frame_i` high. No other cycle moves the serial stream.
- R6: With `buf_en_i` at 1, the data register moves into an empty buffer and the shift register loads from the buffer. With 0, the shift register loads straight from the data register when it is idle or has just sent its last bit.
- R7: `tde_o` is 1 exactly when the data register is empty and, with buffering on, the buffer is empty too. A write via `wr_i` makes it 0 from the next clock.
- R8: `irq_o` is 1 exactly while `tie_i` and `tde_o` are both 1.
- R9: If a word ends and no new word is available, the same word is sent again and `urun_o` is set. It stays set until a `clr_urun_i` pulse.
- R10: While `tx_en_i` is 0, no stage loads, no bit shifts, the bit position resets and `sdo_o` is 0. Writes into the data register are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmitter enable |
| buf_en_i | input | 1 | Use the holding buffer stage |
| gated_clk_i | input | 1 | 1: gated bit clock, 0: continuous clock with frame sync |
| word_len_i | input | 2 | Word length select |
| lsb_first_i | input | 1 | Bit order select |
| tie_i | input | 1 | Transmit interrupt enable |
| bit_en_i | input | 1 | Bit-clock enable, one per serial bit |
| frame_i | input | 1 | Frame sync for continuous-clock style |
| wr_i | input | 1 | Host write strobe for the data register |
| wr_data_i | input | 16 | Host write data |
| clr_urun_i | input | 1 | Clears the underrun flag |
| sdo_o | output | 1 | Serial data out |
| tde_o | output | 1 | Transmit data empty |
| irq_o | output | 1 | Transmit interrupt request |
| urun_o | output | 1 | Sticky underrun flag |

## Verification
Several checks run on every cycle:
- a write always drops the empty flag on the next clock;
- the shift register only takes a word that a stage offers;
- the bit position never passes the selected length;
- a disabled transmitter keeps the line low and its counter cleared;
- the underrun flag is set only when no word was available, and it stays set until cleared.

The actual bit stream can only be shown by the bench scenarios: its order, its justification, its gating by frame sync and the repeat of a word on underrun. The same holds for how the empty flag differs between buffered and direct loading.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int TX_W  = 16;
    localparam int CNT_W = $clog2(TX_W);

    typedef logic [TX_W-1:0]  txw_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // index of the final bit for each length code
    function automatic cnt_t last_idx(input logic [1:0] len);
        case (len)
            2'd0:    return cnt_t'(7);
            2'd1:    return cnt_t'(9);
            2'd2:    return cnt_t'(11);
            default: return cnt_t'(TX_W - 1);
        endcase
    endfunction

    // place the first bit to send at the end the shifter reads from
    function automatic txw_t align(input txw_t w, input logic lsb, input cnt_t lastb);
        return lsb ? (w >> (cnt_t'(TX_W - 1) - lastb)) : w;
    endfunction

    typedef struct packed {
        txw_t dr;
        logic dr_full;
        txw_t bufw;
        logic buf_full;
    } feed_st_t;

    typedef struct packed {
        txw_t sh;
        txw_t last;
        cnt_t cnt;
        logic busy;
        logic urun;
    } shift_st_t;
endpackage

// File: rtl/sst_feed.sv
module sst_feed
    import sst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic buf_en_i,
    input  logic wr_i,
    input  txw_t wr_data_i,
    input  logic take_i,
    output logic avail_o,
    output txw_t word_o,
    output logic tde_o
);
    feed_st_t cur_q, nxt_d;
    logic     move;

    always_comb begin
        nxt_d = cur_q;
        move  = tx_en_i && buf_en_i && cur_q.dr_full && (!cur_q.buf_full || take_i);
        if (take_i && buf_en_i) nxt_d.buf_full = 1'b0;
        if (move) begin
            nxt_d.bufw     = cur_q.dr;
            nxt_d.buf_full = 1'b1;
            nxt_d.dr_full  = 1'b0;
        end
        if (take_i && !buf_en_i) nxt_d.dr_full = 1'b0;
        if (wr_i) begin
            nxt_d.dr      = wr_data_i;
            nxt_d.dr_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign avail_o = buf_en_i ? cur_q.buf_full : cur_q.dr_full;
    assign word_o  = buf_en_i ? cur_q.bufw : cur_q.dr;
    assign tde_o   = !cur_q.dr_full && (!buf_en_i || !cur_q.buf_full);

    AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !tde_o); // R7
    AST_TAKE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> avail_o); // R6
    AST_BUF_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> $stable(cur_q.buf_full)); // R10
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en_i,
    input  logic [1:0] len_i,
    input  logic       lsb_first_i,
    input  logic       step_i,
    input  logic       avail_i,
    input  txw_t       word_i,
    input  logic       clr_urun_i,
    output logic       take_o,
    output logic       sdo_o,
    output logic       urun_o
);
    shift_st_t cur_q, nxt_d;
    cnt_t      lastb;
    logic      done;
    logic      set_urun;

    always_comb begin
        nxt_d    = cur_q;
        take_o   = 1'b0;
        set_urun = 1'b0;
        lastb    = last_idx(len_i);
        done     = cur_q.busy && step_i && (cur_q.cnt >= lastb);
        if (!tx_en_i) begin
            nxt_d.busy = 1'b0;
            nxt_d.cnt  = '0;
        end else begin
            if (cur_q.busy && step_i) begin
                nxt_d.cnt = cur_q.cnt + cnt_t'(1);
                nxt_d.sh  = lsb_first_i ? (cur_q.sh >> 1) : (cur_q.sh << 1);
            end
            if (!cur_q.busy || done) begin
                if (avail_i) begin
                    take_o     = 1'b1;
                    nxt_d.sh   = align(word_i, lsb_first_i, lastb);
                    nxt_d.last = word_i;
                    nxt_d.busy = 1'b1;
                    nxt_d.cnt  = '0;
                end else if (done) begin
                    nxt_d.sh  = align(cur_q.last, lsb_first_i, lastb);
                    nxt_d.cnt = '0;
                    set_urun  = 1'b1;
                end
            end
        end
        if (set_urun)        nxt_d.urun = 1'b1;
        else if (clr_urun_i) nxt_d.urun = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign sdo_o  = tx_en_i && cur_q.busy && (lsb_first_i ? cur_q.sh[0] : cur_q.sh[TX_W-1]);
    assign urun_o = cur_q.urun;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.busy |-> cur_q.cnt <= last_idx(len_i)); // R2
    AST_OFF_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (cur_q.cnt == '0 && !cur_q.busy)); // R10
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_o && !clr_urun_i) |=> urun_o); // R9
    AST_URUN_ONLY_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urun_o) |-> $past(!avail_i)); // R9
endmodule

// File: rtl/sst_tx.sv
module sst_tx
    import sst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en_i,
    input  logic        buf_en_i,
    input  logic        gated_clk_i,
    input  logic [1:0]  word_len_i,
    input  logic        lsb_first_i,
    input  logic        tie_i,
    input  logic        bit_en_i,
    input  logic        frame_i,
    input  logic        wr_i,
    input  logic [15:0] wr_data_i,
    input  logic        clr_urun_i,
    output logic        sdo_o,
    output logic        tde_o,
    output logic        irq_o,
    output logic        urun_o
);
    logic step, take, avail;
    txw_t word;

    assign step = bit_en_i && (gated_clk_i || frame_i);

    sst_feed u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en_i),
        .buf_en_i  (buf_en_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .take_i    (take),
        .avail_o   (avail),
        .word_o    (word),
        .tde_o     (tde_o)
    );

    sst_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en_i     (tx_en_i),
        .len_i       (word_len_i),
        .lsb_first_i (lsb_first_i),
        .step_i      (step),
        .avail_i     (avail),
        .word_i      (word),
        .clr_urun_i  (clr_urun_i),
        .take_o      (take),
        .sdo_o       (sdo_o),
        .urun_o      (urun_o)
    );

    assign irq_o = tie_i && tde_o;

    AST_LINE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |-> !sdo_o); // R10
    AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (tde_o && tie_i)); // R8
endmodule

// File: tb/tb_sst_tx.sv
`timescale 1ns/1ps
module tb_sst_tx;
    logic clk = 1'b0;
    logic rst_n;
    logic tx_en, buf_en, gated, lsb, tie, bit_en, frame, wr, clr;
    logic [1:0]  len;
    logic [15:0] wdata;
    logic sdo, tde, irq, urun;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] words [0:7];
    logic        cap   [0:255];

    always #4 clk = ~clk;

    sst_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .buf_en_i(buf_en),
        .gated_clk_i(gated), .word_len_i(len), .lsb_first_i(lsb), .tie_i(tie),
        .bit_en_i(bit_en), .frame_i(frame), .wr_i(wr), .wr_data_i(wdata),
        .clr_urun_i(clr), .sdo_o(sdo), .tde_o(tde), .irq_o(irq), .urun_o(urun)
    );

    function automatic int nbits(input logic [1:0] l);
        case (l)
            2'd0: return 8;
            2'd1: return 10;
            2'd2: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic logic exp_bit(input logic [15:0] w, input logic [1:0] l,
                                     input logic lf, input int i);
        int n;
        n = nbits(l);
        return lf ? w[16 - n + i] : w[15 - i];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc_in();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_en = 0; buf_en = 0; gated = 0; lsb = 0; tie = 0;
        bit_en = 0; frame = 0; wr = 0; clr = 0; len = 0; wdata = '0;
        repeat (3) cyc_in();
        rst_n = 1'b1;
        cyc_in();
    endtask

    // host write, one cycle strobe
    task automatic hw(input logic [15:0] d);
        wr = 1'b1; wdata = d;
        cyc_in();
        wr = 1'b0;
    endtask

    // n gated shift steps, capturing sdo before each edge
    task automatic steps(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1;
            @(negedge clk);
            cap[base + i] = sdo;
            cyc_in();
        end
        bit_en = 1'b0;
    endtask

    task automatic run_random(input int sidx);
        int nw, n, wi, bits, need, guard, irq_bad;
        bit wrote_prev, ev;
        do_reset();
        len    = 2'($urandom % 4);
        lsb    = 1'($urandom % 2);
        buf_en = 1'($urandom % 2);
        gated  = 1'($urandom % 2);
        tie    = 1'($urandom % 2);
        tx_en  = 1'b1;
        n  = nbits(len);
        nw = 3 + int'($urandom % 4);
        for (int k = 0; k < nw; k++) words[k] = 16'($urandom);
        need = (nw + 1) * n;
        wi = 0; bits = 0; guard = 0; irq_bad = 0; wrote_prev = 1'b0;
        while (bits < need && guard < 4000) begin
            wr = 1'b0;
            if (wi < nw && !wrote_prev && (wi == 0 || tde)) begin
                wr = 1'b1; wdata = words[wi]; wi++;
            end
            wrote_prev = wr;
            bit_en = (guard >= 4) && ($urandom % 4 != 0);
            frame  = ($urandom % 3 != 0);
            ev = bit_en && (gated || frame);
            @(negedge clk);
            if (ev) begin cap[bits] = sdo; bits++; end
            if (irq != (tie && tde)) irq_bad++;
            cyc_in();
            guard++;
        end
        wr = 1'b0; bit_en = 1'b0;
        // R2 R3 R4 R5 R6: each word, last one repeated once
        for (int k = 0; k <= nw; k++) begin
            logic [15:0] src;
            int mism;
            mism = 0;
            src = (k < nw) ? words[k] : words[nw-1];
            for (int b = 0; b < n; b++)
                if (cap[k*n + b] !== exp_bit(src, len, lsb, b)) mism++;
            chk(mism == 0, "R2/R3/R4/R5 word stream", mism, 0);
        end
        chk(irq_bad == 0, "R8 irq qualification", irq_bad, 0);
        @(negedge clk);
        chk(urun == 1'b1, "R9 underrun set after dry word", urun, 1);
        cyc_in();
        clr = 1'b1; cyc_in(); clr = 1'b0;
        @(negedge clk);
        chk(urun == 1'b0, "R9 underrun cleared", urun, 0);
        cyc_in();
        if (sidx < 0) $display("unused");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        do_reset();
        @(negedge clk);
        chk(tde == 1'b1, "R1 tde after reset", tde, 1);
        chk(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(urun == 1'b0, "R1 urun after reset", urun, 0);
        cyc_in();

        // R10: disabled transmitter takes the write but loads and shifts nothing
        tie = 1'b1; gated = 1'b1;
        hw(16'hA5C3);
        bit_en = 1'b1;
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (sdo) hi++;
                cyc_in();
            end
            bit_en = 1'b0;
            chk(hi == 0, "R10 sdo low while disabled", hi, 0);
        end
        @(negedge clk);
        chk(tde == 1'b0, "R10 R7 data held while disabled", tde, 0);
        chk(irq == 1'b0, "R8 irq low while not empty", irq, 0);
        cyc_in();
        tx_en = 1'b1;
        cyc_in();
        @(negedge clk);
        chk(tde == 1'b1, "R6 direct load after enable", tde, 1);
        chk(irq == 1'b1, "R8 irq with tie and empty", irq, 1);
        cyc_in();

        // R6/R7 direct path: second word waits in the data register
        do_reset();
        tx_en = 1'b1; gated = 1'b1;
        hw(16'h3C00);
        @(negedge clk);
        chk(tde == 1'b0, "R7 empty clears after write", tde, 0);
        cyc_in();
        hw(16'hF000);
        repeat (3) cyc_in();
        @(negedge clk);
        chk(tde == 1'b0, "R6 direct: second word held", tde, 0);
        cyc_in();
        steps(8, 0);
        @(negedge clk);
        chk(tde == 1'b1, "R6 direct: empty once shifter takes word", tde, 1);
        begin
            int m;
            m = 0;
            for (int b = 0; b < 8; b++) if (cap[b] !== exp_bit(16'h3C00, 2'd0, 1'b0, b)) m++;
            chk(m == 0, "R4 R2 msb-first 8-bit word", m, 0);
        end
        cyc_in();

        // R6 buffered: buffer full keeps empty flag low
        do_reset();
        tx_en = 1'b1; gated = 1'b1; buf_en = 1'b1; lsb = 1'b1; len = 2'd1;
        hw(16'h81C0);
        repeat (3) cyc_in();
        @(negedge clk);
        chk(tde == 1'b1, "R6 buffered: first word in shifter", tde, 1);
        cyc_in();
        hw(16'h4440);
        cyc_in();
        @(negedge clk);
        chk(tde == 1'b0, "R6 buffered: word in buffer keeps tde low", tde, 0);
        cyc_in();
        hw(16'h0FC0);
        steps(10, 0);
        @(negedge clk);
        chk(tde == 1'b0, "R6 buffered: refill from data register", tde, 0);
        begin
            int m;
            m = 0;
            for (int b = 0; b < 10; b++) if (cap[b] !== exp_bit(16'h81C0, 2'd1, 1'b1, b)) m++;
            chk(m == 0, "R4 R3 lsb-first 10-bit word", m, 0);
        end
        cyc_in();

        for (int s = 0; s < 10; s++) run_random(s);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule